// File: doc/BRIEF.md
# Serial Character Receiver with Sticky Parity Status

This block recovers 8-bit characters from an asynchronous serial input line. The line is first passed through a short synchronizer. A falling edge, seen on an oversampling tick, starts a frame. The tick input pulses sixteen times per bit period. The receiver checks the start bit half a bit later. It then samples every following bit once, at the middle of the bit. The character is presented on a parallel output together with a ready flag. The ready flag stays up until the consumer pulses a read strobe.

When parity is enabled, the received parity bit is compared against the selected rule: even, odd, forced zero or forced one. A mismatch raises a sticky parity-error flag. In the two multidrop codes, no mismatch is computed. Instead, any character whose parity bit is 1 raises the same flag, so the flag marks an address character. The flag stays set until a clear-status command is pulsed. A character that fails the check is still delivered normally.

Top module: `uart_par_rx`

## Requirements
- R1: After reset, `rx_ready` is 0, `par_err` is 0 and `rx_data` is 0x00.
- R2: A frame is: a start bit (0), eight data bits with the least significant bit first, an optional parity bit, and a stop bit. `rx_ready` rises and `rx_data` holds the character after the stop bit is sampled.
- R3: With `par_mode` = 0 (even) the expected parity bit is the XOR of the data bits. With `par_mode` = 1 (odd) it is the inverse of that XOR. A matching bit leaves `par_err` alone; a mismatching bit sets it.
- R4: With `par_mode` = 2 the expected parity bit is 0. With `par_mode` = 3 it is 1. A mismatch sets `par_err`.
- R5: `par_err` stays set until `clr_status` is pulsed. A pulse with no new error clears it on the next clock.
- R6: A character with bad parity is still delivered on `rx_data`, and `rx_ready` is still raised.
- R7: With `par_mode` = 4 or 5 no parity bit is expected: the stop bit follows D7 directly. `par_err` is never set.
- R8: With `par_mode` = 6 or 7 (multidrop) `par_err` is set exactly when the received parity bit is 1, whatever the data.
- R9: If `rxd` is high again at the 8th tick after the start edge, the start is discarded. No character is delivered, and the receiver waits for the next edge.
- R10: A `rd_strobe` pulse clears `rx_ready` on the next clock. Without a pulse `rx_ready` holds. A new character arriving in the same cycle wins over the read.
- R11: If a new parity failure and `clr_status` fall in the same cycle, `par_err` is 1 after that cycle.
- R12: Sampling follows `tick16` only. Each data, parity and stop bit is sampled 16 ticks after the previous sample, so frames decode correctly whatever the spacing of the ticks in clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle pulse, 16 per bit period |
| rxd | input | 1 | Serial data line, idle high |
| par_mode | input | 3 | Parity rule: 0 even, 1 odd, 2 zero, 3 one, 4/5 none, 6/7 multidrop |
| rd_strobe | input | 1 | Consumer read pulse, clears `rx_ready` |
| clr_status | input | 1 | Clear-status command pulse, clears `par_err` |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | A character is waiting to be read |
| par_err | output | 1 | Sticky parity failure / address-received flag |

## Verification
The checker relies on `par_mode` being held constant for the whole of a frame. Its check that the no-parity codes never raise the flag is stated under that condition. It also relies on `tick16` being a single-cycle pulse. The bench changes the mode only while the line has been idle for at least a full bit period. It produces ticks from a free-running divider, so every tick lasts exactly one clock. The bench drives `rxd` in whole bit periods of 16 ticks, apart from the deliberate short glitch that exercises start rejection.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    localparam logic [2:0] PM_EVEN  = 3'd0;
    localparam logic [2:0] PM_ODD   = 3'd1;
    localparam logic [2:0] PM_ZERO  = 3'd2;
    localparam logic [2:0] PM_ONE   = 3'd3;

    // Codes 4 and 5 carry no parity bit
    function automatic logic par_enabled(input logic [2:0] mode);
        return !((mode == 3'd4) || (mode == 3'd5));
    endfunction

    // Codes 6 and 7 are the multidrop modes
    function automatic logic is_multidrop(input logic [2:0] mode);
        return (mode[2:1] == 2'b11);
    endfunction

endpackage

// File: rtl/rx_in_sync.sv
module rx_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] pipe;
    } sync_s;

    sync_s q, d;

    always_comb begin
        d = q;
        if (STAGES > 1) begin
            d.pipe = {q.pipe[STAGES-2:0], din};
        end else begin
            d.pipe[0] = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{pipe: '1};
        else        q <= d;
    end

    assign dout = q.pipe[STAGES-1];
endmodule

// File: rtl/rx_par_calc.sv
module rx_par_calc #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] data,
    input  logic          pbit,
    input  logic [2:0]    mode,
    output logic          bad
);
    import uart_rx_pkg::*;

    logic xsum;

    always_comb begin
        xsum = ^data;
        bad  = 1'b0;
        if (is_multidrop(mode)) begin
            bad = pbit;
        end else if (par_enabled(mode)) begin
            unique case (mode)
                PM_EVEN: bad = (pbit != xsum);
                PM_ODD:  bad = (pbit != ~xsum);
                PM_ZERO: bad = (pbit != 1'b0);
                PM_ONE:  bad = (pbit != 1'b1);
                default: bad = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm #(
    parameter int DW  = 8,
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rxd,
    input  logic          par_en,
    output logic [DW-1:0] shift_data,
    output logic          pbit,
    output logic          par_stb,
    output logic          done
);
    import uart_rx_pkg::*;

    localparam int CW   = $clog2(OVS);
    localparam int HALF = OVS / 2;
    localparam int IW   = (DW > 1) ? $clog2(DW) : 1;

    typedef struct packed {
        rx_state_e     st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] idx;
        logic [DW-1:0] sh;
        logic          pb;
    } fsm_s;

    fsm_s q, d;
    logic par_stb_d, done_d;

    always_comb begin
        d         = q;
        par_stb_d = 1'b0;
        done_d    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (tick && !rxd) begin
                    d.st  = ST_START;
                    d.cnt = '0;
                end
            end
            ST_START: begin
                if (tick) begin
                    if (q.cnt == CW'(HALF - 1)) begin
                        d.cnt = '0;
                        d.idx = '0;
                        d.st  = rxd ? ST_IDLE : ST_DATA;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt = '0;
                        d.sh  = {rxd, q.sh[DW-1:1]};
                        if (q.idx == IW'(DW - 1)) begin
                            d.st = par_en ? ST_PAR : ST_STOP;
                        end else begin
                            d.idx = q.idx + 1'b1;
                        end
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_PAR: begin
                if (tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt     = '0;
                        d.pb      = rxd;
                        d.st      = ST_STOP;
                        par_stb_d = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            ST_STOP: begin
                if (tick) begin
                    if (q.cnt == CW'(OVS - 1)) begin
                        d.cnt  = '0;
                        d.st   = ST_IDLE;
                        done_d = 1'b1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '{st: ST_IDLE, cnt: '0, idx: '0, sh: '0, pb: 1'b0};
            par_stb <= 1'b0;
            done    <= 1'b0;
        end else begin
            q       <= d;
            par_stb <= par_stb_d;
            done    <= done_d;
        end
    end

    assign shift_data = q.sh;
    assign pbit       = q.pb;
endmodule

// File: rtl/uart_par_rx.sv
module uart_par_rx #(
    parameter int DW          = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick16,
    input  logic          rxd,
    input  logic [2:0]    par_mode,
    input  logic          rd_strobe,
    input  logic          clr_status,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          par_err
);
    import uart_rx_pkg::*;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          rdy;
        logic          err;
    } stat_s;

    stat_s q, d;

    logic          rxd_s;
    logic [DW-1:0] shift_data;
    logic          pbit, par_stb, frame_done, par_bad, par_fail;

    rx_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_frame_fsm #(.DW(DW), .OVS(OVS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick16),
        .rxd       (rxd_s),
        .par_en    (par_enabled(par_mode)),
        .shift_data(shift_data),
        .pbit      (pbit),
        .par_stb   (par_stb),
        .done      (frame_done)
    );

    rx_par_calc #(.DW(DW)) u_par (
        .data(shift_data),
        .pbit(pbit),
        .mode(par_mode),
        .bad (par_bad)
    );

    assign par_fail = par_stb && par_bad;

    always_comb begin
        d      = q;
        // a new failure wins over a clear in the same cycle
        d.err  = par_fail | (q.err & ~clr_status);
        // a new character wins over a read in the same cycle
        d.rdy  = frame_done | (q.rdy & ~rd_strobe);
        if (frame_done) d.data = shift_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{data: '0, rdy: 1'b0, err: 1'b0};
        else        q <= d;
    end

    assign rx_data  = q.data;
    assign rx_ready = q.rdy;
    assign par_err  = q.err;
endmodule

// File: rtl/uart_par_rx_chk.sv
module uart_par_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       clr_status,
    input logic       rd_strobe,
    input logic [2:0] par_mode,
    input logic       par_err,
    input logic       rx_ready,
    input logic       fail_pulse,
    input logic       done_pulse
);
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (par_err && !clr_status) |=> par_err); // R5
    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !fail_pulse) |=> !par_err); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_pulse && clr_status) |=> par_err); // R11
    AST_NONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_err) |-> !(($past(par_mode) == 3'd4) || ($past(par_mode) == 3'd5))); // R7
    AST_RDY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe) |=> rx_ready); // R10
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !done_pulse) |=> !rx_ready); // R10
    AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> rx_ready); // R2
endmodule

bind uart_par_rx uart_par_rx_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_status(clr_status),
    .rd_strobe (rd_strobe),
    .par_mode  (par_mode),
    .par_err   (par_err),
    .rx_ready  (rx_ready),
    .fail_pulse(par_fail),
    .done_pulse(frame_done)
);

// File: tb/sim_uart_par_rx.sv
`timescale 1ns/1ps
module sim_uart_par_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rxd = 1'b1;
    logic [2:0] par_mode = 3'd0;
    logic       rd_strobe = 1'b0;
    logic       clr_status = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready;
    logic       par_err;

    int checks = 0;
    int errors = 0;
    int tdiv = 1;
    int tcnt = 0;
    logic mon_en = 1'b0;
    logic seen_err = 1'b0;

    always #10 clk = ~clk;

    uart_par_rx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
        .par_mode(par_mode), .rd_strobe(rd_strobe), .clr_status(clr_status),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err)
    );

    // tick divider driven away from the active edge
    always @(negedge clk) begin
        if (tcnt >= tdiv - 1) begin
            tcnt   <= 0;
            tick16 <= 1'b1;
        end else begin
            tcnt   <= tcnt + 1;
            tick16 <= 1'b0;
        end
        if (mon_en && par_err) seen_err <= 1'b1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bit_time(input logic v);
        rxd = v;
        repeat (16 * tdiv) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] data, input logic has_par, input logic pb);
        bit_time(1'b0);
        for (int i = 0; i < 8; i++) bit_time(data[i]);
        if (has_par) bit_time(pb);
        bit_time(1'b1);
        bit_time(1'b1);
    endtask

    task automatic do_read();
        @(negedge clk) rd_strobe = 1'b1;
        @(negedge clk) rd_strobe = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) clr_status = 1'b1;
        @(negedge clk) clr_status = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 ready", int'(rx_ready), 0);
        chk("R1 par_err", int'(par_err), 0);
        chk("R1 data", int'(rx_data), 0);
    endtask

    task automatic t_even_odd();
        par_mode = 3'd0;
        send(8'h41, 1'b1, 1'b0);
        chk("R2 ready", int'(rx_ready), 1);
        chk("R2 data", int'(rx_data), 'h41);
        chk("R3 even good", int'(par_err), 0);
        do_read();
        par_mode = 3'd1;
        send(8'h41, 1'b1, 1'b1);
        chk("R3 odd good", int'(par_err), 0);
        chk("R2 data odd", int'(rx_data), 'h41);
        do_read();
        send(8'h07, 1'b1, 1'b1);
        chk("R3 odd bad", int'(par_err), 1);
        do_read();
        do_clear();
    endtask

    task automatic t_zero_one();
        par_mode = 3'd2;
        send(8'hFF, 1'b1, 1'b0);
        chk("R4 zero good", int'(par_err), 0);
        do_read();
        par_mode = 3'd3;
        send(8'h00, 1'b1, 1'b1);
        chk("R4 one good", int'(par_err), 0);
        do_read();
        send(8'h00, 1'b1, 1'b0);
        chk("R4 one bad", int'(par_err), 1);
        do_read();
        do_clear();
    endtask

    task automatic t_bad_delivered_sticky();
        par_mode = 3'd0;
        send(8'hA5, 1'b1, 1'b1);
        chk("R6 ready", int'(rx_ready), 1);
        chk("R6 data", int'(rx_data), 'hA5);
        chk("R5 set", int'(par_err), 1);
        do_read();
        send(8'h3C, 1'b1, 1'b0);
        chk("R5 sticky", int'(par_err), 1);
        chk("R2 data 3C", int'(rx_data), 'h3C);
        do_read();
        do_clear();
        @(negedge clk);
        chk("R5 cleared", int'(par_err), 0);
    endtask

    task automatic t_none();
        for (int m = 4; m <= 5; m++) begin
            par_mode = 3'(m);
            send(8'h96, 1'b0, 1'b0);
            chk("R7 data", int'(rx_data), 'h96);
            chk("R7 ready", int'(rx_ready), 1);
            chk("R7 no err", int'(par_err), 0);
            do_read();
        end
    endtask

    task automatic t_multidrop();
        for (int m = 6; m <= 7; m++) begin
            par_mode = 3'(m);
            send(8'h12, 1'b1, 1'b0);
            chk("R8 data char", int'(par_err), 0);
            do_read();
            send(8'h12, 1'b1, 1'b1);
            chk("R8 address char", int'(par_err), 1);
            chk("R8 addr data", int'(rx_data), 'h12);
            do_read();
            do_clear();
        end
    endtask

    task automatic t_false_start();
        par_mode = 3'd0;
        rxd = 1'b0;
        repeat (4 * tdiv) @(negedge clk);
        bit_time(1'b1);
        bit_time(1'b1);
        chk("R9 no char", int'(rx_ready), 0);
        send(8'h5A, 1'b1, 1'b0);
        chk("R9 next frame", int'(rx_data), 'h5A);
        do_read();
    endtask

    task automatic t_read();
        par_mode = 3'd0;
        send(8'hC3, 1'b1, 1'b0);
        repeat (5) @(negedge clk);
        chk("R10 holds", int'(rx_ready), 1);
        do_read();
        chk("R10 cleared", int'(rx_ready), 0);
    endtask

    task automatic t_set_vs_clear();
        par_mode = 3'd0;
        seen_err = 1'b0;
        @(negedge clk) clr_status = 1'b1;
        mon_en = 1'b1;
        send(8'h01, 1'b1, 1'b0);
        mon_en = 1'b0;
        clr_status = 1'b0;
        chk("R11 set seen under clear", int'(seen_err), 1);
        chk("R11 later cleared", int'(par_err), 0);
        do_read();
    endtask

    task automatic t_slow_ticks();
        tdiv = 3;
        repeat (20) @(negedge clk);
        par_mode = 3'd1;
        send(8'h6E, 1'b1, 1'b0);
        chk("R12 data", int'(rx_data), 'h6E);
        chk("R12 odd good", int'(par_err), 0);
        do_read();
        tdiv = 1;
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_even_odd();
        t_zero_one();
        t_bad_delivered_sticky();
        t_none();
        t_multidrop();
        t_false_start();
        t_read();
        t_set_vs_clear();
        t_slow_ticks();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule